// File: doc/BRIEF.md
# EPROM Pulse-Verify Programming Sequencer

This controller writes a byte-wide, UV-erasable EPROM from a source that provides one byte per address. It steps through the whole device starting at address zero. At each address it takes the intended byte and applies a program pulse of fixed length. It then reads the cell back and compares it with the intended byte. If they differ it applies another pulse, up to a bounded number of attempts. The pulse width and the read access delay are counted in clock cycles. Bytes that already equal the erased value are not pulsed. An erased cell reads as all ones, and programming can only clear bits.

After the last address has been programmed, the sequencer reads every location again in a separate pass, at the nominal supply level. It compares each byte with the source. Three flag outputs tell external supply circuitry which level to generate: program voltage present, raised supply for the program loop, or nominal supply for the final pass. The sequencer reports success with a one-cycle done pulse. It reports failure with a held fail flag and the address that failed.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is held and afterwards in idle, dev_ce_n_o and dev_oe_n_o are 1, dev_wdata_en_o, done_o, fail_o and all three supply flags are 0.
- R2: Each program pulse holds dev_ce_n_o=0, dev_oe_n_o=1, dev_wdata_en_o=1, vpp_prog_o=1 and vcc_high_o=1 for exactly PULSE_CYC cycles. During the pulse, dev_wdata_o carries the source byte of the current address.
- R3: Every readback holds dev_ce_n_o=0 and dev_oe_n_o=0 for exactly ACCESS_CYC cycles. dev_rdata_i is sampled at the clock edge that ends the last of those cycles.
- R4: After a pulse whose readback differs from the source byte, another pulse is applied to the same address. Pulsing at an address stops at the first matching readback.
- R5: If MAX_PULSES pulses leave an address unmatched, fail_o rises and fail_addr_o holds that address. No further device access follows. Both outputs hold until start_i.
- R6: Addresses are programmed, and later verified, in ascending order from 0 to 2^ADDR_W-1. Each address is finished before the next one starts.
- R7: With SKIP_ERASED=1, an address whose source byte is 8'hFF receives no pulse.
- R8: After the last address, each location is read exactly once in ascending order with vcc_nom_o=1 and vpp_prog_o=vcc_high_o=0. No pulse is applied in this pass. This pass is skipped if programming failed.
- R9: A verify readback that differs from the source byte raises fail_o with fail_addr_o set to that address. Verification stops there.
- R10: When every verify read matches, done_o is 1 for exactly one cycle and the block returns to idle.
- R11: vcc_high_o and vcc_nom_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a run from idle or from the fail state |
| src_addr_o | output | ADDR_W | Address presented to the data source |
| src_data_i | input | DATA_W | Source byte for src_addr_o, valid in the same cycle |
| dev_addr_o | output | ADDR_W | Device address |
| dev_ce_n_o | output | 1 | Device chip enable, active low |
| dev_oe_n_o | output | 1 | Device output enable, active low |
| dev_wdata_o | output | DATA_W | Byte driven to the device during a pulse |
| dev_wdata_en_o | output | 1 | Data bus drive enable (pulse active) |
| dev_rdata_i | input | DATA_W | Byte read from the device |
| vpp_prog_o | output | 1 | Request program voltage on the device |
| vcc_high_o | output | 1 | Request raised supply for the program loop |
| vcc_nom_o | output | 1 | Request nominal supplies for the final verify pass |
| done_o | output | 1 | One-cycle success indication |
| fail_o | output | 1 | Held failure indication |
| fail_addr_o | output | ADDR_W | Address of the failure |

## Verification
A wrong attempt count shows in the number of pulses per address at the device pins. It also changes whether fail or done ends the run and when. A timer or access-delay error shows as a wrong pulse or read width on the enables. It can also make the design sample early, which gives a false mismatch and an extra pulse at that same address. An address or phase error shows as an out-of-order pulse, a missing verify read, or a wrong fail address at the end of the run. The device model counts every pulse and read run, so each of these errors is caught within one address of where it occurs.

// File: rtl/eprom_prog_pkg.sv
// Package: shared sequencer state encoding for the EPROM programming block.
package eprom_prog_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_P_SETUP,
        ST_P_PULSE,
        ST_P_READ,
        ST_P_NEXT,
        ST_V_READ,
        ST_V_NEXT,
        ST_DONE,
        ST_FAIL
    } seq_state_e;
endpackage

// File: rtl/eprom_cycle_timer.sv
// Module: eprom_cycle_timer
// Down-counter that times a phase in clock cycles. Loading N-1 keeps zero_o
// low for N-1 cycles, so a state that waits for zero_o lasts exactly N cycles.
// Assumes the owner loads it on entry to the phase being timed.
module eprom_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o); // R2
endmodule

// File: rtl/eprom_try_counter.sv
// Module: eprom_try_counter
// Counts program pulses spent on the current address. last_o flags that the
// permitted number of attempts has been used. Assumes clr_i and inc_i may
// arrive together when the first pulse of a new address starts.
module eprom_try_counter #(
    parameter int MAX_TRIES = 25,
    localparam int CW = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] count_o,
    output logic          last_o
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

    logic [CW-1:0] cnt_q;

    // Restart per address; add one for each pulse issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= inc_i ? CW'(1) : '0;
        else if (inc_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
    assign last_o  = (cnt_q == LIMIT);

    AST_TRY_NO_EXCESS: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> !inc_i || clr_i); // R5
endmodule

// File: rtl/eprom_prog_seq.sv
// Module: eprom_prog_seq (top)
// Programs every address of an attached EPROM with pulse/readback/retry
// loops, then verifies the whole array at nominal supply. Assumes src_data_i
// is valid in the same cycle as src_addr_o and that the device data bus is
// released whenever dev_wdata_en_o is low.
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int PULSE_CYC   = 12500,
    parameter int ACCESS_CYC  = 4,
    parameter int MAX_PULSES  = 25,
    parameter bit SKIP_ERASED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] src_addr_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic              dev_ce_n_o,
    output logic              dev_oe_n_o,
    output logic [DATA_W-1:0] dev_wdata_o,
    output logic              dev_wdata_en_o,
    input  logic [DATA_W-1:0] dev_rdata_i,
    output logic              vpp_prog_o,
    output logic              vcc_high_o,
    output logic              vcc_nom_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o
);
    localparam int TMR_MAX = (PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int TRY_W   = $clog2(MAX_PULSES + 1);
    localparam int RUN_W   = TMR_W + 1;
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [DATA_W-1:0] ERASED    = {DATA_W{1'b1}};
    localparam logic [TMR_W-1:0]  PULSE_LD  = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0]  READ_LD   = TMR_W'(ACCESS_CYC - 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, fail_addr_q;
    logic [DATA_W-1:0] data_q;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              try_clr, try_inc, try_last;
    logic [TRY_W-1:0]  try_cnt;
    logic              addr_clr, addr_inc, data_cap, fail_cap;

    eprom_cycle_timer #(.CNT_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    eprom_try_counter #(.MAX_TRIES(MAX_PULSES)) u_tries (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (try_clr),
        .inc_i   (try_inc),
        .count_o (try_cnt),
        .last_o  (try_last)
    );

    // Sequencer: next state and the per-transition control strobes.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        data_cap = 1'b0;
        fail_cap = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FAIL: begin
                if (start_i) begin
                    addr_clr = 1'b1;
                    state_d  = ST_P_SETUP;
                end
            end
            ST_P_SETUP: begin
                data_cap = 1'b1;
                try_clr  = 1'b1;
                if (SKIP_ERASED && (src_data_i == ERASED)) begin
                    state_d = ST_P_NEXT;
                end else begin
                    try_inc  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LD;
                    state_d  = ST_P_PULSE;
                end
            end
            ST_P_PULSE: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = READ_LD;
                    state_d  = ST_P_READ;
                end
            end
            ST_P_READ: begin
                if (tmr_zero) begin
                    if (dev_rdata_i == data_q) begin
                        state_d = ST_P_NEXT;
                    end else if (try_last) begin
                        fail_cap = 1'b1;
                        state_d  = ST_FAIL;
                    end else begin
                        try_inc  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = PULSE_LD;
                        state_d  = ST_P_PULSE;
                    end
                end
            end
            ST_P_NEXT: begin
                if (addr_q == LAST_ADDR) begin
                    addr_clr = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = READ_LD;
                    state_d  = ST_V_READ;
                end else begin
                    addr_inc = 1'b1;
                    state_d  = ST_P_SETUP;
                end
            end
            ST_V_READ: begin
                if (tmr_zero) begin
                    if (dev_rdata_i == src_data_i) begin
                        state_d = ST_V_NEXT;
                    end else begin
                        fail_cap = 1'b1;
                        state_d  = ST_FAIL;
                    end
                end
            end
            ST_V_NEXT: begin
                if (addr_q == LAST_ADDR) begin
                    state_d = ST_DONE;
                end else begin
                    addr_inc = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = READ_LD;
                    state_d  = ST_V_READ;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, address, captured byte and fail address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            data_q      <= '0;
            fail_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (addr_clr)
                addr_q <= '0;
            else if (addr_inc)
                addr_q <= addr_q + 1'b1;
            if (data_cap)
                data_q <= src_data_i;
            if (fail_cap)
                fail_addr_q <= addr_q;
        end
    end

    // Device pins and supply requests decoded from the state.
    always_comb begin
        dev_ce_n_o     = 1'b1;
        dev_oe_n_o     = 1'b1;
        dev_wdata_en_o = 1'b0;
        vpp_prog_o     = 1'b0;
        vcc_high_o     = 1'b0;
        vcc_nom_o      = 1'b0;
        unique case (state_q)
            ST_P_SETUP, ST_P_NEXT: begin
                vpp_prog_o = 1'b1;
                vcc_high_o = 1'b1;
            end
            ST_P_PULSE: begin
                dev_ce_n_o     = 1'b0;
                dev_wdata_en_o = 1'b1;
                vpp_prog_o     = 1'b1;
                vcc_high_o     = 1'b1;
            end
            ST_P_READ: begin
                dev_ce_n_o = 1'b0;
                dev_oe_n_o = 1'b0;
                vpp_prog_o = 1'b1;
                vcc_high_o = 1'b1;
            end
            ST_V_READ: begin
                dev_ce_n_o = 1'b0;
                dev_oe_n_o = 1'b0;
                vcc_nom_o  = 1'b1;
            end
            ST_V_NEXT: vcc_nom_o = 1'b1;
            default: ;
        endcase
    end

    assign src_addr_o  = addr_q;
    assign dev_addr_o  = addr_q;
    assign dev_wdata_o = data_q;
    assign done_o      = (state_q == ST_DONE);
    assign fail_o      = (state_q == ST_FAIL);
    assign fail_addr_o = fail_addr_q;

    // Checker: length of the current pulse and read runs at the pins.
    logic [RUN_W-1:0] pulse_run_q, read_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_run_q <= '0;
            read_run_q  <= '0;
        end else begin
            pulse_run_q <= dev_wdata_en_o ? pulse_run_q + 1'b1 : '0;
            read_run_q  <= !dev_oe_n_o ? read_run_q + 1'b1 : '0;
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_wdata_en_o) |-> pulse_run_q == RUN_W'(PULSE_CYC)); // R2
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_wdata_en_o && !dev_oe_n_o)); // R2
    AST_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_oe_n_o) |-> read_run_q == RUN_W'(ACCESS_CYC)); // R3
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wdata_en_o |-> (try_cnt != '0) && (try_cnt <= TRY_W'(MAX_PULSES))); // R5
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o && $stable(fail_addr_o) && dev_ce_n_o); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P_SETUP && $past(state_q) == ST_P_NEXT)
            |-> addr_q == $past(addr_q) + ADDR_W'(1)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && dev_ce_n_o); // R10
    AST_SUPPLY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vcc_high_o && vcc_nom_o)); // R11
endmodule

// File: tb/eprom_prog_seq_tb.sv
// Bench: small device (16 addresses) modelled behaviourally. A cell needs a
// per-address number of pulses before its bits clear, and it returns valid
// data only after ACCESS_CYC-1 completed read cycles.
module eprom_prog_seq_tb;
    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam int PC = 20;
    localparam int AC = 3;
    localparam int MP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] src_addr, dev_addr, fail_addr;
    logic [7:0] src_data, wdata, rdata;
    logic ce_n, oe_n, wen, vpp, vhi, vnom, done, fail;

    always #4 clk = ~clk;

    // Stimulus tables (written by the initial block only).
    logic [7:0] src  [N];
    logic [7:0] init [N];
    int         need [N];
    int         ck;
    logic [7:0] cmask;
    logic       cor_en = 1'b0;
    logic       clr_stats = 1'b0;

    // Model state (written by the model block only).
    logic [7:0] mem [N];
    int pcount [N];
    int vreads [N];
    int prun, orun, last_p, last_v;
    int bad_len, bad_rlen, bad_order, bad_data;
    logic [AW-1:0] r_addr;
    logic r_nom, cor_done;

    int nchk = 0;
    int nfail = 0;

    assign src_data = src[src_addr];
    assign rdata = (!ce_n && !oe_n) ?
                   ((orun >= AC - 1) ? mem[dev_addr] : ~mem[dev_addr]) : 8'hFF;

    eprom_prog_seq #(
        .ADDR_W(AW), .DATA_W(8), .PULSE_CYC(PC), .ACCESS_CYC(AC),
        .MAX_PULSES(MP), .SKIP_ERASED(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .src_addr_o(src_addr), .src_data_i(src_data),
        .dev_addr_o(dev_addr), .dev_ce_n_o(ce_n), .dev_oe_n_o(oe_n),
        .dev_wdata_o(wdata), .dev_wdata_en_o(wen), .dev_rdata_i(rdata),
        .vpp_prog_o(vpp), .vcc_high_o(vhi), .vcc_nom_o(vnom),
        .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr)
    );

    // Device model: pulse/read accounting, programming and verify disturbance.
    always @(posedge clk) begin
        if (clr_stats) begin
            for (int i = 0; i < N; i++) begin
                mem[i] <= init[i]; pcount[i] <= 0; vreads[i] <= 0;
            end
            prun <= 0; orun <= 0; last_p <= 0; last_v <= 0;
            bad_len <= 0; bad_rlen <= 0; bad_order <= 0; bad_data <= 0;
            cor_done <= 1'b0;
        end else begin
            if (wen) begin
                prun <= prun + 1;
                if (prun + 1 == PC) begin
                    pcount[dev_addr] <= pcount[dev_addr] + 1;
                    if (pcount[dev_addr] + 1 >= need[dev_addr])
                        mem[dev_addr] <= mem[dev_addr] & wdata;
                    if (wdata != src[dev_addr]) bad_data <= bad_data + 1;
                    if (int'(dev_addr) < last_p) bad_order <= bad_order + 1;
                    last_p <= int'(dev_addr);
                end
            end else if (prun != 0) begin
                if (prun != PC) bad_len <= bad_len + 1;
                prun <= 0;
            end
            if (!ce_n && !oe_n) begin
                orun <= orun + 1; r_addr <= dev_addr; r_nom <= vnom;
            end else if (orun != 0) begin
                if (orun != AC) bad_rlen <= bad_rlen + 1;
                if (r_nom) begin
                    vreads[r_addr] <= vreads[r_addr] + 1;
                    if (int'(r_addr) < last_v) bad_order <= bad_order + 1;
                    last_v <= int'(r_addr);
                end
                orun <= 0;
            end
            if (cor_en && vnom && !cor_done) begin
                mem[ck] <= mem[ck] & ~cmask;
                cor_done <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected pulse count at an address, from R4/R5/R7.
    function automatic int exp_pulses(input int a);
        if (src[a] == 8'hFF) return 0;
        if (init[a] == src[a]) return 1;
        if (((init[a] & src[a]) == src[a]) && need[a] <= MP) return need[a];
        return MP;
    endfunction

    function automatic bit prog_fails(input int a);
        return (src[a] != 8'hFF) && (init[a] != src[a]) &&
               !(((init[a] & src[a]) == src[a]) && need[a] <= MP);
    endfunction

    task automatic gen_random(input int maxneed);
        for (int i = 0; i < N; i++) begin
            src[i]  = ($urandom % 5 == 0) ? 8'hFF : 8'($urandom);
            init[i] = 8'hFF;
            need[i] = 1 + int'($urandom % maxneed);
        end
        cor_en = 1'b0;
    endtask

    task automatic run_case(input string name);
        int pfail, vfail, cyc, bad_sup;
        bit got_done, got_fail;
        logic [AW-1:0] fa;
        pfail = -1; vfail = -1; bad_sup = 0;
        for (int i = N - 1; i >= 0; i--) if (prog_fails(i)) pfail = i;
        if (pfail < 0 && cor_en) vfail = ck;
        @(negedge clk); clr_stats = 1'b1;
        @(negedge clk); clr_stats = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        got_done = 1'b0; got_fail = 1'b0; cyc = 0;
        while (!got_done && !got_fail && cyc < 20000) begin
            if (vhi && vnom) bad_sup++;
            if (wen && !(vpp && vhi && !ce_n && oe_n)) bad_sup++;
            if (vnom && (vpp || wen)) bad_sup++;
            got_done = done; got_fail = fail;
            if (!got_done && !got_fail) begin @(negedge clk); cyc++; end
        end
        chk(cyc < 20000, "R10", {name, " watchdog"}, cyc, 20000);
        if (pfail >= 0) begin
            chk(got_fail, "R5", {name, " fail raised"}, got_fail, 1);
            chk(int'(fail_addr) == pfail, "R5", {name, " fail addr"}, fail_addr, pfail);
        end else if (vfail >= 0) begin
            chk(got_fail, "R9", {name, " verify fail"}, got_fail, 1);
            chk(int'(fail_addr) == vfail, "R9", {name, " fail addr"}, fail_addr, vfail);
        end else begin
            chk(got_done && !got_fail, "R10", {name, " done"}, got_done, 1);
        end
        fa = fail_addr;
        @(negedge clk);
        if (got_done) chk(!done && ce_n && !fail, "R10", {name, " one-cycle done"}, done, 0);
        if (got_fail) begin
            repeat (8) @(negedge clk);
            chk(fail && fail_addr == fa && ce_n && oe_n, "R5", {name, " fail held"},
                {fail, fail_addr}, {1'b1, fa});
        end
        for (int a = 0; a < N; a++) begin
            int e;
            e = (pfail >= 0 && a > pfail) ? 0 : exp_pulses(a);
            chk(pcount[a] == e, (src[a] == 8'hFF) ? "R7" : "R4",
                $sformatf("%s pulses@%0d", name, a), pcount[a], e);
        end
        begin
            int vbad;
            vbad = 0;
            for (int a = 0; a < N; a++) begin
                int e;
                e = (pfail >= 0) ? 0 : ((vfail >= 0 && a > vfail) ? 0 : 1);
                if (vreads[a] != e) vbad++;
            end
            chk(vbad == 0, "R8", {name, " verify reads"}, vbad, 0);
        end
        chk(bad_len == 0 && bad_data == 0, "R2", {name, " pulse width/data"},
            bad_len + bad_data, 0);
        chk(bad_rlen == 0, "R3", {name, " read width"}, bad_rlen, 0);
        chk(bad_order == 0, "R6", {name, " ascending order"}, bad_order, 0);
        chk(bad_sup == 0, "R11", {name, " supply flags"}, bad_sup, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) begin
            src[i] = 8'hFF; init[i] = 8'hFF; need[i] = 1;
        end
        ck = 0; cmask = 8'h00;
        repeat (4) @(negedge clk);
        chk(ce_n && oe_n && !wen && !done && !fail && !vpp && !vhi && !vnom,
            "R1", "reset outputs", {ce_n, oe_n, wen, done, fail}, 5'b11000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ce_n && oe_n && !wen && !done && !fail && !vpp && !vhi && !vnom,
            "R1", "idle outputs", {ce_n, oe_n, wen, done, fail}, 5'b11000);

        // All erased source: nothing pulsed (R7), then full verify (R8).
        run_case("all_ff");
        // Every programmable address needs exactly MP pulses (R4 boundary).
        gen_random(1);
        for (int i = 0; i < N; i++) need[i] = MP;
        run_case("need_max");
        // One address needs MP+1 pulses: fail there (R5).
        gen_random(3);
        src[9] = 8'h3C; need[9] = MP + 1;
        run_case("need_over");
        // Last address cannot be reached (a 0 must turn into 1): fail at 15 (R5).
        gen_random(3);
        init[15] = 8'h0F; src[15] = 8'hF0;
        run_case("last_impossible");
        // Cell disturbed before verify: verify pass fails at that address (R9).
        gen_random(3);
        src[6] = 8'h5A; ck = 6; cmask = 8'h02; cor_en = 1'b1;
        run_case("verify_disturb");
        cor_en = 1'b0;
        // Pre-programmed cell matches after a single pulse (R4).
        gen_random(3);
        src[3] = 8'hA5; init[3] = 8'hA5; need[3] = 4;
        run_case("preprogrammed");
        // Constrained random runs.
        for (int r = 0; r < 6; r++) begin
            gen_random(MP);
            if (r == 4) begin src[0] = 8'h00; need[0] = MP + 2; end
            run_case($sformatf("rand%0d", r));
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Global watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R10 global watchdog actual=%0d expected=%0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule